// File: doc/BRIEF.md
# Bus-Matching FIFO with Status Flags

This block is a single-clock first-in first-out buffer whose storage holds 36-bit words. The write port and the read port can each carry a full word or a narrower slice: a 9-bit or 18-bit writer can feed a 36-bit reader, and a 36-bit writer can feed a 36-, 18- or 9-bit reader. A narrow writer's slices are packed into one stored word. A narrow reader receives a stored word in slices. A byte-order select sets which end of the word moves first.

Two read timing styles are offered. In the registered style, each read strobe loads one slice into the output register. In the look-ahead style, the head slice is always visible on the output, and a read strobe moves on to the next slice. The block also drives a half-full flag and two almost flags. The offsets of the almost flags are set at master reset from a small preset table. They can later be rewritten, either all at once from the data bus or one bit per clock. A partial reset empties the buffer but keeps every setting. A master reset clears everything and reloads the settings.

Top module: `busmatch_fifo`

## Requirements
- R1: On a clock with `mrst_i` high, the block latches `bus_mode_i`, `big_end_i` and `fwft_i`. The bus mode codes are: 0 = write 36 / read 36, 1 = write 36 / read 18, 2 = write 36 / read 9, 3 = write 18 / read 36, 4 = write 9 / read 36. Codes 5 to 7 act as code 0. Narrow write data is taken from the low bits of `wdata_i`.
- R2: A narrow writer builds each stored word from 2 or 4 slices. The word becomes readable only after its last slice is written. With `big_end_i`=1, the first slice fills bits [35:18] (18-bit) or [35:27] (9-bit), and later slices fill the positions below in turn. With `big_end_i`=0, the first slice fills [17:0] or [8:0], and later slices fill the positions above in turn.
- R3: A narrow reader returns each word as slices on the low bits of `rdata_o`, with the upper bits at zero. The slices come out in the same byte order that R2 uses. The word leaves the buffer only after its last slice is read.
- R4: In registered mode (`fwft_i`=0 at master reset), `out_flag_o`=1 means the buffer is empty. On a read with the buffer not empty, `rdata_o` takes the next slice on that clock edge. Otherwise `rdata_o` holds its value.
- R5: In look-ahead mode (`fwft_i`=1), `out_flag_o`=1 means a valid slice is on `rdata_o`. The first word written into an empty buffer appears after its committing edge, with no read strobe. A read moves on to the next slice.
- R6: `in_flag_o` reports storage that is full (registered mode) or storage that has space (look-ahead mode). Occupancy is counted in whole 36-bit words, and DEPTH words fit.
- R7: A write while full and a read while empty are ignored, and the pointers do not move. A write and a read in the same cycle are both carried out.
- R8: `half_o` is 1 exactly when more than DEPTH/2 words are stored.
- R9: One clock after the stored count C is seen, `almost_empty_o` = (C <= AE offset) and `almost_full_o` = (DEPTH-C <= AF offset). After either reset, the almost-empty flag reads 1 and the almost-full flag reads 0.
- R10: Master reset loads both offsets with min(`preset_i`+1, DEPTH/2).
- R11: A clock with `ld_par_i` high loads the AE offset from `wdata_i`[CW-1:0] and the AF offset from `wdata_i`[18+CW-1:18]. Here CW = clog2(DEPTH+1). No FIFO write occurs in that cycle.
- R12: Each clock with `ld_ser_i` high shifts `ser_d_i` into the top of the joined register {AF, AE}. After 2*CW shifts, the first bit shifted in sits in AE bit 0.
- R13: Partial reset empties the buffer and clears the slice positions. It keeps the offsets, bus mode, byte order and timing mode, and it ignores the select inputs.
- R14: Master reset empties the buffer and replaces all settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_i | input | 1 | Master reset, synchronous, active high |
| prst_i | input | 1 | Partial reset, synchronous, active high |
| bus_mode_i | input | 3 | Port width pairing, latched at master reset |
| big_end_i | input | 1 | Byte order select, latched at master reset |
| fwft_i | input | 1 | Look-ahead timing select, latched at master reset |
| preset_i | input | 3 | Offset preset select for master reset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 36 | Write data and parallel offset data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 36 | Read data |
| ld_par_i | input | 1 | Parallel offset load |
| ld_ser_i | input | 1 | Serial offset shift enable |
| ser_d_i | input | 1 | Serial offset data bit |
| out_flag_o | output | 1 | Empty (registered) or output ready (look-ahead) |
| in_flag_o | output | 1 | Full (registered) or input ready (look-ahead) |
| half_o | output | 1 | More than half full |
| almost_empty_o | output | 1 | Almost-empty flag |
| almost_full_o | output | 1 | Almost-full flag |

## Verification
The hardest case to reach is a partial reset that must keep hidden settings. Those settings are a loaded offset, a narrow read width and a byte order, and none of them shows at the ports directly. The bench therefore changes every select input before the partial reset. It then proves each kept setting through behaviour: the almost-empty flag flips at the loaded offset and not at the new preset, and the next word comes out in 9-bit slices in the original order. The one-cycle lag of the almost flags gets the same treatment: each flag is sampled once on the edge where the count moves and once a clock later.

// File: rtl/bmf_pkg.sv
`timescale 1ns/1ps
package bmf_pkg;

    localparam int WORD_W = 36;

    typedef enum logic [2:0] {
        BM_W36_R36 = 3'd0,
        BM_W36_R18 = 3'd1,
        BM_W36_R9  = 3'd2,
        BM_W18_R36 = 3'd3,
        BM_W9_R36  = 3'd4
    } bm_mode_e;

    typedef struct packed {
        bm_mode_e mode;
        logic     big;
        logic     fwft;
    } bmf_cfg_t;

    function automatic bm_mode_e decode_mode(input logic [2:0] code);
        if (code <= 3'd4) return bm_mode_e'(code);
        return BM_W36_R36;
    endfunction

    // log2 of slices per word on the write side
    function automatic logic [1:0] wr_lanes_lg(input bm_mode_e m);
        case (m)
            BM_W18_R36: return 2'd1;
            BM_W9_R36:  return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] rd_lanes_lg(input bm_mode_e m);
        case (m)
            BM_W36_R18: return 2'd1;
            BM_W36_R9:  return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] lane_last(input logic [1:0] lg);
        case (lg)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] put_slice(
        input logic [WORD_W-1:0] acc, input logic [WORD_W-1:0] din,
        input logic [1:0] lg, input logic [1:0] idx, input logic big);
        logic [WORD_W-1:0] r;
        logic [1:0]        p;
        r = acc;
        case (lg)
            2'd0: r = din;
            2'd1: begin
                if (big ? ~idx[0] : idx[0]) r[35:18] = din[17:0];
                else                        r[17:0]  = din[17:0];
            end
            default: begin
                p = big ? (2'd3 - idx) : idx;
                r[9*int'(p) +: 9] = din[8:0];
            end
        endcase
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] get_slice(
        input logic [WORD_W-1:0] w, input logic [1:0] lg,
        input logic [1:0] idx, input logic big);
        logic [1:0] p;
        case (lg)
            2'd0: return w;
            2'd1: begin
                if (big ? ~idx[0] : idx[0]) return {18'b0, w[35:18]};
                return {18'b0, w[17:0]};
            end
            default: begin
                p = big ? (2'd3 - idx) : idx;
                return {27'b0, w[9*int'(p) +: 9]};
            end
        endcase
    endfunction

    function automatic int unsigned preset_off(input logic [2:0] sel,
                                               input int unsigned depth);
        int unsigned v;
        v = int'(sel) + 1;
        return (v > depth / 2) ? depth / 2 : v;
    endfunction

endpackage

// File: rtl/bmf_wr_pack.sv
`timescale 1ns/1ps
module bmf_wr_pack
    import bmf_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic [1:0]        lane_lg,
    input  logic              big,
    input  logic              accept,
    input  logic [WORD_W-1:0] din,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] acc_q;
    logic [1:0]        idx_q;
    logic              last;

    assign last     = (idx_q == lane_last(lane_lg));
    assign word_o   = put_slice(acc_q, din, lane_lg, idx_q, big);
    assign commit_o = accept & last;

    always_ff @(posedge clk) begin
        if (clr) begin
            acc_q <= '0;
            idx_q <= '0;
        end else if (accept) begin
            if (last) begin
                acc_q <= '0;
                idx_q <= '0;
            end else begin
                acc_q <= word_o;
                idx_q <= idx_q + 2'd1;
            end
        end
    end

    // R2
    pack_restart_chk: assert property (@(posedge clk) disable iff (clr)
        commit_o |=> (idx_q == 2'd0));
    // R2
    pack_partial_chk: assert property (@(posedge clk) disable iff (clr)
        (accept && !last) |=> (idx_q != 2'd0));
endmodule

// File: rtl/bmf_rd_unpack.sv
`timescale 1ns/1ps
module bmf_rd_unpack
    import bmf_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic [1:0]        lane_lg,
    input  logic              big,
    input  logic              take,
    input  logic [WORD_W-1:0] head,
    output logic [WORD_W-1:0] slice_o,
    output logic              free_o
);
    logic [1:0] idx_q;
    logic       last;

    assign last    = (idx_q == lane_last(lane_lg));
    assign slice_o = get_slice(head, lane_lg, idx_q, big);
    assign free_o  = take & last;

    always_ff @(posedge clk) begin
        if (clr)       idx_q <= '0;
        else if (take) idx_q <= last ? 2'd0 : idx_q + 2'd1;
    end

    // R3
    unpack_mid_chk: assert property (@(posedge clk) disable iff (clr)
        (take && !free_o) |=> (idx_q != 2'd0));
    // R3
    unpack_done_chk: assert property (@(posedge clk) disable iff (clr)
        free_o |=> (idx_q == 2'd0));
endmodule

// File: rtl/bmf_flags.sv
`timescale 1ns/1ps
module bmf_flags
    import bmf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic [2:0]    preset_sel,
    input  logic          par_ld,
    input  logic [CW-1:0] par_ae,
    input  logic [CW-1:0] par_af,
    input  logic          ser_en,
    input  logic          ser_d,
    input  logic [CW-1:0] cnt,
    output logic          ae_o,
    output logic          af_o,
    output logic          hf_o
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic [CW-1:0]   ae_off_q, af_off_q, free_cnt;
    logic [2*CW-1:0] joined;

    assign free_cnt = FULL_CNT - cnt;
    assign joined   = {af_off_q, ae_off_q};
    assign hf_o     = (cnt > HALF_CNT);

    always_ff @(posedge clk) begin
        if (mrst) begin
            ae_off_q <= CW'(preset_off(preset_sel, DEPTH));
            af_off_q <= CW'(preset_off(preset_sel, DEPTH));
        end else if (par_ld) begin
            ae_off_q <= par_ae;
            af_off_q <= par_af;
        end else if (ser_en) begin
            {af_off_q, ae_off_q} <= {ser_d, joined[2*CW-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            ae_o <= 1'b1;
            af_o <= 1'b0;
        end else begin
            ae_o <= (cnt <= ae_off_q);
            af_o <= (free_cnt <= af_off_q);
        end
    end

    // R9
    ae_set_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (cnt <= ae_off_q) |=> ae_o);
    // R9
    ae_clr_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (cnt > ae_off_q) |=> !ae_o);
    // R9
    af_set_chk: assert property (@(posedge clk) disable iff (mrst || prst)
        (free_cnt <= af_off_q) |=> af_o);
    // R13
    prst_keep_off_chk: assert property (@(posedge clk) disable iff (mrst)
        (prst && !par_ld && !ser_en) |=> $stable(joined));
endmodule

// File: rtl/busmatch_fifo.sv
`timescale 1ns/1ps
module busmatch_fifo
    import bmf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              mrst_i,
    input  logic              prst_i,
    input  logic [2:0]        bus_mode_i,
    input  logic              big_end_i,
    input  logic              fwft_i,
    input  logic [2:0]        preset_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rdata_o,
    input  logic              ld_par_i,
    input  logic              ld_ser_i,
    input  logic              ser_d_i,
    output logic              out_flag_o,
    output logic              in_flag_o,
    output logic              half_o,
    output logic              almost_empty_o,
    output logic              almost_full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    bmf_cfg_t          cfg_q;
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp_q, rp_q;
    logic [CW-1:0]     cnt_q;
    logic [WORD_W-1:0] rdata_q, word, slice;
    logic              clr, full, empty, wr_accept, rd_take, commit, free;

    assign clr       = mrst_i | prst_i;
    assign full      = (cnt_q == FULL_CNT);
    assign empty     = (cnt_q == '0);
    assign wr_accept = wr_en_i & ~ld_par_i & ~full & ~clr;
    assign rd_take   = rd_en_i & ~empty & ~clr;

    always_ff @(posedge clk) begin
        if (mrst_i) begin
            cfg_q.mode <= decode_mode(bus_mode_i);
            cfg_q.big  <= big_end_i;
            cfg_q.fwft <= fwft_i;
        end
    end

    bmf_wr_pack u_pack (
        .clk      (clk),
        .clr      (clr),
        .lane_lg  (wr_lanes_lg(cfg_q.mode)),
        .big      (cfg_q.big),
        .accept   (wr_accept),
        .din      (wdata_i),
        .commit_o (commit),
        .word_o   (word)
    );

    bmf_rd_unpack u_unpack (
        .clk     (clk),
        .clr     (clr),
        .lane_lg (rd_lanes_lg(cfg_q.mode)),
        .big     (cfg_q.big),
        .take    (rd_take),
        .head    (mem[rp_q]),
        .slice_o (slice),
        .free_o  (free)
    );

    always_ff @(posedge clk) begin
        if (commit) mem[wp_q] <= word;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wp_q    <= '0;
            rp_q    <= '0;
            cnt_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (commit) wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
            if (free)   rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(commit) - CW'(free);
            if (rd_take) rdata_q <= slice;
        end
    end

    bmf_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .clk        (clk),
        .mrst       (mrst_i),
        .prst       (prst_i),
        .preset_sel (preset_i),
        .par_ld     (ld_par_i),
        .par_ae     (wdata_i[CW-1:0]),
        .par_af     (wdata_i[18 +: CW]),
        .ser_en     (ld_ser_i),
        .ser_d      (ser_d_i),
        .cnt        (cnt_q),
        .ae_o       (almost_empty_o),
        .af_o       (almost_full_o),
        .hf_o       (half_o)
    );

    assign rdata_o    = cfg_q.fwft ? (empty ? '0 : slice) : rdata_q;
    assign out_flag_o = cfg_q.fwft ? ~empty : empty;
    assign in_flag_o  = cfg_q.fwft ? ~full  : full;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (clr)
        (full && wr_en_i) |=> $stable(wp_q));
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (clr)
        (empty && rd_en_i) |=> ($stable(rp_q) && $stable(rdata_q)));
    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (clr)
        cnt_q <= FULL_CNT);
    // R13
    cfg_hold_chk: assert property (@(posedge clk) disable iff (mrst_i)
        !mrst_i |=> $stable(cfg_q));
endmodule

// File: tb/busmatch_fifo_tb_top.sv
`timescale 1ns/1ps
module busmatch_fifo_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        mrst_i = 1'b1, prst_i = 1'b0;
    logic [2:0]  bus_mode_i = 3'd0, preset_i = 3'd0;
    logic        big_end_i = 1'b0, fwft_i = 1'b0;
    logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [35:0] wdata_i = '0;
    logic        ld_par_i = 1'b0, ld_ser_i = 1'b0, ser_d_i = 1'b0;
    logic [35:0] rdata_o;
    logic        out_flag_o, in_flag_o, half_o, almost_empty_o, almost_full_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    busmatch_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .mrst_i(mrst_i), .prst_i(prst_i), .bus_mode_i(bus_mode_i),
        .big_end_i(big_end_i), .fwft_i(fwft_i), .preset_i(preset_i),
        .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i),
        .rdata_o(rdata_o), .ld_par_i(ld_par_i), .ld_ser_i(ld_ser_i),
        .ser_d_i(ser_d_i), .out_flag_o(out_flag_o), .in_flag_o(in_flag_o),
        .half_o(half_o), .almost_empty_o(almost_empty_o),
        .almost_full_o(almost_full_o)
    );

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic mreset(input logic [2:0] m, input logic b,
                          input logic f, input logic [2:0] p);
        bus_mode_i = m; big_end_i = b; fwft_i = f; preset_i = p;
        mrst_i = 1'b1;
        tick();
        mrst_i = 1'b0;
    endtask

    task automatic push(input logic [35:0] d);
        wr_en_i = 1'b1; wdata_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic pop();
        rd_en_i = 1'b1;
        tick();
        rd_en_i = 1'b0;
    endtask

    task automatic t_reset();
        mreset(3'd0, 1'b0, 1'b0, 3'd2);
        chk("R4 reset empty", out_flag_o, 1);
        chk("R6 reset not full", in_flag_o, 0);
        chk("R8 reset half", half_o, 0);
        chk("R9 reset ae", almost_empty_o, 1);
        chk("R9 reset af", almost_full_o, 0);
    endtask

    task automatic t_basic();
        mreset(3'd0, 1'b0, 1'b0, 3'd0);
        push(36'h1_1111_1111); push(36'h2_2222_2222); push(36'h3_3333_3333);
        chk("R4 not empty", out_flag_o, 0);
        pop(); chk("R1 word a", rdata_o, 36'h1_1111_1111);
        pop(); chk("R4 word b", rdata_o, 36'h2_2222_2222);
        pop(); chk("R4 word c", rdata_o, 36'h3_3333_3333);
        chk("R4 empty again", out_flag_o, 1);
        pop(); chk("R7 read while empty holds", rdata_o, 36'h3_3333_3333);
        push(36'h4_0000_0004);
        wr_en_i = 1'b1; rd_en_i = 1'b1; wdata_i = 36'h5_0000_0005;
        tick();
        wr_en_i = 1'b0; rd_en_i = 1'b0;
        chk("R7 simultaneous read data", rdata_o, 36'h4_0000_0004);
        chk("R7 simultaneous write kept", out_flag_o, 0);
        pop(); chk("R7 simultaneous word", rdata_o, 36'h5_0000_0005);
        chk("R7 drained", out_flag_o, 1);
    endtask

    task automatic t_narrow_read();
        logic [35:0] w;
        w = 36'hA_BCDE_F012;
        mreset(3'd2, 1'b1, 1'b0, 3'd0);
        push(w);
        for (int k = 0; k < 4; k++) begin
            if (k == 3) chk("R3 word held until last slice", out_flag_o, 0);
            pop();
            chk("R3 9-bit big slice", rdata_o, {27'b0, w[35-9*k -: 9]});
        end
        chk("R3 word freed", out_flag_o, 1);
        mreset(3'd1, 1'b0, 1'b0, 3'd0);
        push(w);
        pop(); chk("R3 18-bit little first", rdata_o, {18'b0, w[17:0]});
        pop(); chk("R3 18-bit little second", rdata_o, {18'b0, w[35:18]});
    endtask

    task automatic t_narrow_write();
        mreset(3'd4, 1'b0, 1'b0, 3'd0);
        push(36'h0_0000_0011); push(36'h0_0000_0022); push(36'h0_0000_0033);
        chk("R2 not committed before last slice", out_flag_o, 1);
        push(36'h0_0000_0144);
        chk("R2 committed", out_flag_o, 0);
        pop();
        chk("R2 9-bit little pack", rdata_o, {9'h144, 9'h033, 9'h022, 9'h011});
        mreset(3'd3, 1'b1, 1'b0, 3'd0);
        push(36'h0_0001_2345); push(36'h0_0003_ABCD);
        pop();
        chk("R2 18-bit big pack", rdata_o, {18'h12345, 18'h3ABCD});
    endtask

    task automatic t_fwft();
        mreset(3'd0, 1'b0, 1'b1, 3'd0);
        chk("R5 not ready", out_flag_o, 0);
        chk("R6 input ready", in_flag_o, 1);
        push(36'h7_7777_0001);
        chk("R5 ready without read", out_flag_o, 1);
        chk("R5 first word falls through", rdata_o, 36'h7_7777_0001);
        push(36'h7_7777_0002);
        pop(); chk("R5 next word", rdata_o, 36'h7_7777_0002);
        pop(); chk("R5 drained", out_flag_o, 0);
    endtask

    task automatic t_full_half();
        mreset(3'd0, 1'b0, 1'b0, 3'd0);
        for (int i = 0; i < 8; i++) push(36'h100 + 36'(i));
        chk("R8 at half not set", half_o, 0);
        push(36'h108);
        chk("R8 above half set", half_o, 1);
        for (int i = 9; i < DEPTH; i++) push(36'h100 + 36'(i));
        chk("R6 full", in_flag_o, 1);
        push(36'hBAD);
        for (int i = 0; i < DEPTH; i++) begin
            pop();
            chk("R7 order after write while full", rdata_o, 36'h100 + 36'(i));
        end
        chk("R7 extra write dropped", out_flag_o, 1);
    endtask

    task automatic t_almost_preset();
        mreset(3'd0, 1'b0, 1'b0, 3'd2);
        for (int i = 0; i < 3; i++) push(36'(i));
        tick(); chk("R10 ae at offset 3", almost_empty_o, 1);
        push(36'h3);
        chk("R9 ae lags one clock", almost_empty_o, 1);
        tick(); chk("R9 ae clears", almost_empty_o, 0);
        for (int i = 4; i < 12; i++) push(36'(i));
        tick(); chk("R9 af clear at free 4", almost_full_o, 0);
        push(36'hC);
        chk("R9 af lags one clock", almost_full_o, 0);
        tick(); chk("R10 af at free 3", almost_full_o, 1);
    endtask

    task automatic t_parallel();
        mreset(3'd0, 1'b0, 1'b0, 3'd0);
        ld_par_i = 1'b1; wr_en_i = 1'b1; wdata_i = (36'd1 << 18) | 36'd5;
        tick();
        ld_par_i = 1'b0; wr_en_i = 1'b0;
        chk("R11 no write on load", out_flag_o, 1);
        for (int i = 0; i < 5; i++) push(36'(i));
        tick(); chk("R11 ae offset 5 held", almost_empty_o, 1);
        push(36'h5);
        tick(); chk("R11 ae offset 5 cleared", almost_empty_o, 0);
        for (int i = 6; i < 14; i++) push(36'(i));
        tick(); chk("R11 af off at free 2", almost_full_o, 0);
        push(36'hE);
        tick(); chk("R11 af on at free 1", almost_full_o, 1);
    endtask

    task automatic t_serial();
        logic [4:0] ae_v, af_v;
        ae_v = 5'd2; af_v = 5'd4;
        mreset(3'd0, 1'b0, 1'b0, 3'd7);
        for (int i = 0; i < 10; i++) begin
            ld_ser_i = 1'b1;
            ser_d_i  = (i < 5) ? ae_v[i] : af_v[i-5];
            tick();
        end
        ld_ser_i = 1'b0;
        push(36'h1); push(36'h2);
        tick(); chk("R12 ae offset 2 held", almost_empty_o, 1);
        push(36'h3);
        tick(); chk("R12 ae offset 2 cleared", almost_empty_o, 0);
        for (int i = 3; i < 11; i++) push(36'(i));
        tick(); chk("R12 af off at free 5", almost_full_o, 0);
        push(36'hB);
        tick(); chk("R12 af on at free 4", almost_full_o, 1);
    endtask

    task automatic t_partial();
        logic [35:0] w;
        w = 36'h5_A5C3_9E71;
        mreset(3'd2, 1'b1, 1'b0, 3'd0);
        ld_par_i = 1'b1; wdata_i = (36'd1 << 18) | 36'd5;
        tick();
        ld_par_i = 1'b0;
        push(36'h1); push(36'h2);
        bus_mode_i = 3'd0; big_end_i = 1'b0; fwft_i = 1'b1; preset_i = 3'd7;
        prst_i = 1'b1;
        tick();
        prst_i = 1'b0;
        chk("R13 data cleared, timing kept", out_flag_o, 1);
        chk("R13 ae after partial reset", almost_empty_o, 1);
        push(w);
        for (int i = 0; i < 4; i++) push(36'(i));
        tick(); chk("R13 offset kept (held)", almost_empty_o, 1);
        push(36'h4);
        tick(); chk("R13 offset kept (cleared)", almost_empty_o, 0);
        for (int k = 0; k < 4; k++) begin
            pop();
            chk("R13 width and order kept", rdata_o, {27'b0, w[35-9*k -: 9]});
        end
    endtask

    task automatic t_master();
        mreset(3'd7, 1'b1, 1'b0, 3'd0);
        chk("R14 data cleared", out_flag_o, 1);
        push(36'h9_8765_4321);
        tick(); chk("R14 preset offset 1 held", almost_empty_o, 1);
        push(36'h2);
        tick(); chk("R14 preset offset 1 cleared", almost_empty_o, 0);
        pop(); chk("R1 illegal code acts as full width", rdata_o, 36'h9_8765_4321);
    endtask

    initial begin
        #1;
        t_reset();
        t_basic();
        t_narrow_read();
        t_narrow_write();
        t_fwft();
        t_full_half();
        t_almost_preset();
        t_parallel();
        t_serial();
        t_partial();
        t_master();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule